// File: doc/BRIEF.md
# Hardware Cursor Overlay

This block lays a 16 by 16 pixel pointer over a stream of 24-bit display pixels. The pointer image is held in a small on-block shape store with two bit planes. Each row of the image takes a 16-byte slot in a byte-addressed write port. Within a row's slot, one plane says which pixels the cursor owns and the other picks the colour. An owned pixel shows the foreground or background colour. An unowned pixel either lets the underlying pixel through or shows its bitwise inverse.

Software writes the shape through the byte port. It sets the enable bit, the two colours and the pointer position through a small register port. The display pipeline supplies the current beam coordinates and the underlying pixel each cycle, and receives the blended pixel one clock later. Position writes are staged and only take effect on a frame-sync pulse, which the display controller gives at the start of vertical blank, so the pointer never moves halfway down a frame.

Top module: `cursor_overlay`

## Requirements
- R1: After reset the cursor is disabled, the foreground colour is 0xFFFFFF, the background colour is 0x000000, the active and staged position is (0,0), and every shape pixel is transparent.
- R2: While the cursor is disabled, `pix_out` equals the `pix_in` of the previous cycle, whatever the beam position or shape.
- R3: Shape byte address `row*16 + off` (row in address bits 7:4) maps as follows. Offsets 0 and 1 hold the colour plane of that row. Offsets 8 and 9 hold the ownership plane, which is the complement of an AND mask. Writes to any other offset are ignored.
- R4: Within a row, the byte at offset 0 (or 8) covers columns 0 to 7 and the byte at offset 1 (or 9) covers columns 8 to 15. Bit 7 of each byte is the leftmost column.
- R5: For a pixel inside the cursor with ownership bit p and colour bit c: p=0,c=0 passes `pix_in`; p=1,c=0 gives the background colour; p=1,c=1 gives the foreground colour; p=0,c=1 gives the bitwise inverse of `pix_in`.
- R6: A beam pixel is inside the cursor when pos_x <= beam_x < pos_x+16 and pos_y <= beam_y < pos_y+16. Outside that window `pix_out` is the previous `pix_in`.
- R7: The register port uses these selects: 0 is control, 1 is x position, 2 is y position, 3 is foreground, 4 is background. Writes to selects 1 and 2 are staged and only become active in the cycle after `frame_sync` is high. If a position write and `frame_sync` happen in the same cycle, the newly written value becomes active.
- R8: Writes to the foreground and background selects take effect for the next pixel, using `reg_wdata[23:0]`.
- R9: Bit 0 of the control register enables the cursor. Writing 0 to it hides the cursor.
- R10: `pix_out` is registered: it reflects the inputs of the previous clock edge and does not change between edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 3 | Register select |
| reg_wdata | input | 24 | Register write data |
| shp_we | input | 1 | Shape byte write strobe |
| shp_addr | input | 8 | Shape byte address (row in bits 7:4, offset in bits 3:0) |
| shp_wdata | input | 8 | Shape byte data |
| frame_sync | input | 1 | One-cycle pulse at start of vertical blank |
| beam_x | input | 12 | Current pixel column |
| beam_y | input | 12 | Current pixel line |
| pix_in | input | 24 | Underlying pixel |
| pix_out | output | 24 | Blended pixel, one cycle later |

## Verification
The position staging and the frame-sync transfer can fall in the same cycle. The bench provokes this by driving an x-position write with `frame_sync` high on the same edge. It then judges the result at the ports: a shaped pixel must appear at the newly written column, not at the old one. The bench also checks the plain cases on either side. A staged write without a sync must leave the pointer where it was, and a later sync alone must move it.

// File: rtl/cursor_pkg.sv
package cursor_pkg;
  localparam int CUR_DIM = 16;
  localparam int CUR_IDX_W = $clog2(CUR_DIM);
  localparam int SLOT_BYTES = 16;

  typedef enum logic [2:0] {
    SEL_CTRL = 3'd0,
    SEL_POSX = 3'd1,
    SEL_POSY = 3'd2,
    SEL_FG   = 3'd3,
    SEL_BG   = 3'd4
  } reg_sel_e;
endpackage

// File: rtl/cursor_ctrl_regs.sv
module cursor_ctrl_regs
  import cursor_pkg::*;
#(
  parameter int COLOR_W = 24,
  parameter int COORD_W = 12
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_we,
  input  logic [2:0]         reg_sel,
  input  logic [COLOR_W-1:0] reg_wdata,
  input  logic               frame_sync,
  output logic               en,
  output logic [COLOR_W-1:0] fg,
  output logic [COLOR_W-1:0] bg,
  output logic [COORD_W-1:0] pos_x,
  output logic [COORD_W-1:0] pos_y
);
  logic               en_q, en_d;
  logic [COLOR_W-1:0] fg_q, fg_d, bg_q, bg_d;
  logic [COORD_W-1:0] stg_x_q, stg_x_d, stg_y_q, stg_y_d;
  logic [COORD_W-1:0] act_x_q, act_x_d, act_y_q, act_y_d;

  always_comb begin
    en_d    = en_q;
    fg_d    = fg_q;
    bg_d    = bg_q;
    stg_x_d = stg_x_q;
    stg_y_d = stg_y_q;
    if (reg_we) begin
      case (reg_sel)
        SEL_CTRL: en_d    = reg_wdata[0];
        SEL_POSX: stg_x_d = reg_wdata[COORD_W-1:0];
        SEL_POSY: stg_y_d = reg_wdata[COORD_W-1:0];
        SEL_FG:   fg_d    = reg_wdata;
        SEL_BG:   bg_d    = reg_wdata;
        default:  ;
      endcase
    end
    act_x_d = frame_sync ? stg_x_d : act_x_q;
    act_y_d = frame_sync ? stg_y_d : act_y_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q    <= 1'b0;
      fg_q    <= {COLOR_W{1'b1}};
      bg_q    <= '0;
      stg_x_q <= '0;
      stg_y_q <= '0;
      act_x_q <= '0;
      act_y_q <= '0;
    end else begin
      en_q    <= en_d;
      fg_q    <= fg_d;
      bg_q    <= bg_d;
      stg_x_q <= stg_x_d;
      stg_y_q <= stg_y_d;
      act_x_q <= act_x_d;
      act_y_q <= act_y_d;
    end
  end

  assign en    = en_q;
  assign fg    = fg_q;
  assign bg    = bg_q;
  assign pos_x = act_x_q;
  assign pos_y = act_y_q;

  // R7: active position only moves on a frame-sync cycle
  a_r7_pos_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_sync |=> ($stable(act_x_q) && $stable(act_y_q)));
  // R7: a sync with no coincident write transfers the staged x value
  a_r7_pos_load: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_sync && !(reg_we && reg_sel == SEL_POSX)) |=> act_x_q == $past(stg_x_q));
  // R8: foreground write lands in the next cycle
  a_r8_fg_write: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_sel == SEL_FG) |=> fg_q == $past(reg_wdata));
endmodule

// File: rtl/cursor_shape_store.sv
module cursor_shape_store
  import cursor_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 shp_we,
  input  logic [7:0]           shp_addr,
  input  logic [7:0]           shp_wdata,
  input  logic [CUR_IDX_W-1:0] rd_row,
  output logic [CUR_DIM-1:0]   rd_color,
  output logic [CUR_DIM-1:0]   rd_own
);
  logic [CUR_DIM-1:0] color_q [CUR_DIM];
  logic [CUR_DIM-1:0] own_q   [CUR_DIM];

  logic [3:0] wr_off;
  assign wr_off = shp_addr[3:0];

  for (genvar r = 0; r < CUR_DIM; r++) begin : g_row
    logic               row_hit;
    logic [CUR_DIM-1:0] color_d, own_d;
    logic               row_ce;

    assign row_hit = shp_we && (shp_addr[7:4] == CUR_IDX_W'(r));

    always_comb begin
      color_d = color_q[r];
      own_d   = own_q[r];
      row_ce  = 1'b0;
      if (row_hit) begin
        case (wr_off)
          4'd0: begin color_d[15:8] = shp_wdata; row_ce = 1'b1; end
          4'd1: begin color_d[7:0]  = shp_wdata; row_ce = 1'b1; end
          4'd8: begin own_d[15:8]   = shp_wdata; row_ce = 1'b1; end
          4'd9: begin own_d[7:0]    = shp_wdata; row_ce = 1'b1; end
          default: ;
        endcase
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        color_q[r] <= '0;
        own_q[r]   <= '0;
      end else if (row_ce) begin
        color_q[r] <= color_d;
        own_q[r]   <= own_d;
      end
    end

    // R3: a write to an unmapped offset leaves the row unchanged
    a_r3_unmapped_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (row_hit && wr_off != 4'd0 && wr_off != 4'd1 && wr_off != 4'd8 && wr_off != 4'd9)
      |=> ($stable(color_q[r]) && $stable(own_q[r])));
  end

  assign rd_color = color_q[rd_row];
  assign rd_own   = own_q[rd_row];
endmodule

// File: rtl/cursor_blend.sv
module cursor_blend #(
  parameter int COLOR_W = 24
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               show,
  input  logic               own_bit,
  input  logic               color_bit,
  input  logic [COLOR_W-1:0] pix_in,
  input  logic [COLOR_W-1:0] fg,
  input  logic [COLOR_W-1:0] bg,
  output logic [COLOR_W-1:0] pix_out
);
  logic [COLOR_W-1:0] mix_d, out_q;

  always_comb begin
    mix_d = pix_in;
    if (show) begin
      case ({own_bit, color_bit})
        2'b00: mix_d = pix_in;
        2'b01: mix_d = ~pix_in;
        2'b10: mix_d = bg;
        2'b11: mix_d = fg;
        default: mix_d = pix_in;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_q <= '0;
    else        out_q <= mix_d;
  end

  assign pix_out = out_q;

  // R5: invert case yields the inverse of the previous input pixel
  a_r5_invert: assert property (@(posedge clk) disable iff (!rst_n)
    (show && !own_bit && color_bit) |=> pix_out == ~$past(pix_in));
  // R6: pixels outside the window pass through one cycle later
  a_r6_outside_pass: assert property (@(posedge clk) disable iff (!rst_n)
    !show |=> pix_out == $past(pix_in));
endmodule

// File: rtl/cursor_overlay.sv
module cursor_overlay
  import cursor_pkg::*;
#(
  parameter int COLOR_W = 24,
  parameter int COORD_W = 12
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_we,
  input  logic [2:0]         reg_sel,
  input  logic [COLOR_W-1:0] reg_wdata,
  input  logic               shp_we,
  input  logic [7:0]         shp_addr,
  input  logic [7:0]         shp_wdata,
  input  logic               frame_sync,
  input  logic [COORD_W-1:0] beam_x,
  input  logic [COORD_W-1:0] beam_y,
  input  logic [COLOR_W-1:0] pix_in,
  output logic [COLOR_W-1:0] pix_out
);
  localparam int DW = COORD_W + 1;

  logic               en;
  logic [COLOR_W-1:0] fg, bg;
  logic [COORD_W-1:0] pos_x, pos_y;
  logic [DW-1:0]      dx, dy;
  logic               in_x, in_y, show;
  logic [CUR_DIM-1:0] row_color, row_own;
  logic [CUR_IDX_W-1:0] col, row, bit_idx;

  cursor_ctrl_regs #(.COLOR_W(COLOR_W), .COORD_W(COORD_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .frame_sync(frame_sync), .en(en), .fg(fg),
    .bg(bg), .pos_x(pos_x), .pos_y(pos_y)
  );

  assign dx   = {1'b0, beam_x} - {1'b0, pos_x};
  assign dy   = {1'b0, beam_y} - {1'b0, pos_y};
  assign in_x = (dx[DW-1:CUR_IDX_W] == '0);
  assign in_y = (dy[DW-1:CUR_IDX_W] == '0);
  assign col  = dx[CUR_IDX_W-1:0];
  assign row  = dy[CUR_IDX_W-1:0];
  assign show = en && in_x && in_y;
  assign bit_idx = ~col;

  cursor_shape_store u_store (
    .clk(clk), .rst_n(rst_n), .shp_we(shp_we), .shp_addr(shp_addr),
    .shp_wdata(shp_wdata), .rd_row(row), .rd_color(row_color), .rd_own(row_own)
  );

  cursor_blend #(.COLOR_W(COLOR_W)) u_blend (
    .clk(clk), .rst_n(rst_n), .show(show), .own_bit(row_own[bit_idx]),
    .color_bit(row_color[bit_idx]), .pix_in(pix_in), .fg(fg), .bg(bg),
    .pix_out(pix_out)
  );

  // R2: a disabled cursor never alters the pixel
  a_r2_disabled_pass: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> pix_out == $past(pix_in));
  // R9: control write of 0 hides the cursor from the following cycle
  a_r9_hide: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_sel == SEL_CTRL && !reg_wdata[0]) |=> !en);
endmodule

// File: tb/cursor_overlay_bench.sv
module cursor_overlay_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_sel = '0;
  logic [23:0] reg_wdata = '0;
  logic        shp_we = 1'b0;
  logic [7:0]  shp_addr = '0;
  logic [7:0]  shp_wdata = '0;
  logic        frame_sync = 1'b0;
  logic [11:0] beam_x = '0;
  logic [11:0] beam_y = '0;
  logic [23:0] pix_in = '0;
  logic [23:0] pix_out;

  int checks = 0;
  int fails = 0;

  cursor_overlay u_cursor_overlay (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .shp_we(shp_we), .shp_addr(shp_addr),
    .shp_wdata(shp_wdata), .frame_sync(frame_sync), .beam_x(beam_x),
    .beam_y(beam_y), .pix_in(pix_in), .pix_out(pix_out)
  );

  always #4 clk = ~clk;

  task automatic check(input string tag, input logic [23:0] act, input logic [23:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %06h expected %06h", tag, act, exp);
    end
  endtask

  task automatic reg_write(input logic [2:0] sel, input logic [23:0] d, input logic sync);
    reg_we = 1'b1; reg_sel = sel; reg_wdata = d; frame_sync = sync;
    @(negedge clk);
    reg_we = 1'b0; frame_sync = 1'b0;
  endtask

  task automatic sync_pulse();
    frame_sync = 1'b1;
    @(negedge clk);
    frame_sync = 1'b0;
  endtask

  task automatic shp_write(input logic [7:0] a, input logic [7:0] d);
    shp_we = 1'b1; shp_addr = a; shp_wdata = d;
    @(negedge clk);
    shp_we = 1'b0;
  endtask

  task automatic probe(input string tag, input int x, input int y,
                       input logic [23:0] pin, input logic [23:0] exp);
    beam_x = 12'(x); beam_y = 12'(y); pix_in = pin;
    @(negedge clk);
    check(tag, pix_out, exp);
  endtask

  task automatic t_reset();
    probe("R1 reset disabled passes", 0, 0, 24'h123456, 24'h123456);
    probe("R2 disabled ignores beam", 3, 3, 24'h654321, 24'h654321);
  endtask

  task automatic t_latency();
    pix_in = 24'hABCDEF;
    #2;
    check("R10 no change between edges", pix_out, 24'h654321);
    @(negedge clk);
    check("R10 one cycle later", pix_out, 24'hABCDEF);
  endtask

  task automatic t_shape_defaults();
    shp_write(8'h00, 8'h80);
    shp_write(8'h01, 8'h01);
    shp_write(8'h08, 8'hC0);
    shp_write(8'h09, 8'h00);
    shp_write(8'h04, 8'hFF);
    shp_write(8'h0C, 8'hFF);
    reg_write(3'd0, 24'h1, 1'b0);
    probe("R1 default fg R5 R4", 0, 0, 24'h111111, 24'hFFFFFF);
    probe("R1 default bg R5", 1, 0, 24'h111111, 24'h000000);
    probe("R5 invert col15 R4", 15, 0, 24'h0F0F0F, 24'hF0F0F0);
    probe("R3 unmapped offset ignored", 2, 0, 24'h222222, 24'h222222);
    probe("R3 unmapped offset 12 ignored", 4, 0, 24'h333333, 24'h333333);
  endtask

  task automatic t_colours();
    reg_write(3'd3, 24'h00AA55, 1'b0);
    reg_write(3'd4, 24'h123400, 1'b0);
    probe("R8 fg write", 0, 0, 24'h0, 24'h00AA55);
    probe("R8 bg write", 1, 0, 24'h0, 24'h123400);
  endtask

  task automatic t_rows();
    shp_write(8'h51, 8'h01);
    shp_write(8'h59, 8'h01);
    probe("R3 row5 fg", 15, 5, 24'h444444, 24'h00AA55);
    probe("R3 row4 transparent", 15, 4, 24'h555555, 24'h555555);
  endtask

  task automatic t_position();
    reg_write(3'd1, 24'd100, 1'b0);
    reg_write(3'd2, 24'd50, 1'b0);
    probe("R7 staged not active", 0, 0, 24'h0, 24'h00AA55);
    sync_pulse();
    probe("R7 moved after sync", 100, 50, 24'h0, 24'h00AA55);
    probe("R6 old spot outside", 0, 0, 24'h777777, 24'h777777);
    probe("R6 right edge outside", 116, 50, 24'h888888, 24'h888888);
    probe("R6 left outside", 99, 50, 24'h898989, 24'h898989);
    probe("R6 last column inside row5", 115, 55, 24'h0, 24'h00AA55);
    probe("R6 below outside", 100, 66, 24'h999999, 24'h999999);
  endtask

  task automatic t_sync_collision();
    reg_write(3'd1, 24'd200, 1'b1);
    probe("R7 same-cycle write and sync new x", 200, 50, 24'h0, 24'h00AA55);
    probe("R7 same-cycle old x gone", 100, 50, 24'h121212, 24'h121212);
  endtask

  task automatic t_hide();
    reg_write(3'd0, 24'h0, 1'b0);
    probe("R9 hidden passes", 200, 50, 24'h131313, 24'h131313);
    reg_write(3'd0, 24'h1, 1'b0);
    probe("R9 re-enabled", 200, 50, 24'h131313, 24'h00AA55);
  endtask

  initial begin
    #(8 * 200000);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_latency();
    t_shape_defaults();
    t_colours();
    t_rows();
    t_position();
    t_sync_collision();
    t_hide();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule